// File: doc/BRIEF.md
# Memory Read ECC Checker

This block sits on the read return path from memory to the CPU. Each read beat arrives with its address, 64 data bits and 8 check bits of a Hamming SECDED code. The block recomputes the check bits and forms the syndrome. It corrects any single flipped bit and returns the data one cycle later. Each returned beat carries a bus-error flag, which is set when the error cannot be corrected.

The two error classes are handled differently. A correctable error is repaired quietly, and an interrupt follows only if a configuration input asks for it. An uncorrectable error always sets a sticky interrupt and the bus-error flag, and the raw data is returned as it arrived. The first error of either class is recorded in a set of report registers: address, raw data, raw check bits and a class flag. The record holds until software clears it, and any later error only sets an overflow bit.

Top module: `mem_ecc_checker`

## Requirements
- R1: Code layout. Hamming positions run from 1 to 71. The powers of two are reserved for check bits, and data bit j takes the j-th remaining position in ascending order. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. A word that matches this code is returned unchanged, with no bus error, no interrupt and no report.
- R2: If exactly one data bit is flipped, that bit is restored in the returned data and the beat carries no bus error.
- R3: If exactly one check bit is flipped (bit 7 included), the data is returned unchanged and the error is classed as correctable.
- R4: If the syndrome is nonzero and the overall parity matches, the error is uncorrectable. The returned beat carries out_bus_err = 1, out_data equals the raw rd_data, and irq is set.
- R5: If the overall parity is odd but the syndrome is above 71, the error is classed as uncorrectable and handled as in R4.
- R6: A correctable error sets irq only when sbe_irq_en is 1 in the cycle the beat is sampled.
- R7: irq stays set until an irq_clr pulse clears it. If an error that sets irq arrives in the same cycle as irq_clr, irq stays set.
- R8: On an error, if no record is held, the block captures rd_addr, the raw rd_data, the raw rd_chk and rpt_double (1 = uncorrectable, 0 = correctable), and sets rpt_valid.
- R9: While rpt_valid is 1, later errors leave the record unchanged and set rpt_overflow. A rpt_clr pulse clears rpt_valid and rpt_overflow. An error in the same cycle as rpt_clr is captured as a fresh record.
- R10: out_valid is high exactly one cycle after rd_valid is sampled. out_data and out_bus_err belong to that same beat, and out_bus_err is never high without out_valid.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read beat present |
| rd_addr | input | ADDR_W | Address of the beat |
| rd_data | input | DATA_W | Raw data from memory |
| rd_chk | input | CHK_W | Raw check bits from memory |
| sbe_irq_en | input | 1 | Let correctable errors set the interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq |
| rpt_clr | input | 1 | Clear pulse for the report record |
| out_valid | output | 1 | Returned beat valid |
| out_data | output | DATA_W | Corrected data |
| out_bus_err | output | 1 | Uncorrectable error on this beat |
| irq | output | 1 | Sticky error interrupt |
| rpt_valid | output | 1 | Report record held |
| rpt_overflow | output | 1 | Error seen while a record was held |
| rpt_addr | output | ADDR_W | Captured address |
| rpt_data | output | DATA_W | Captured raw data |
| rpt_chk | output | CHK_W | Captured raw check bits |
| rpt_double | output | 1 | Captured error was uncorrectable |

## Verification
The bench builds the block with the default 64-bit data and 8 check bits, which gives the full 72-position code. Under this layout, syndromes 72 to 127 cannot come from any single flip, so the out-of-range case in R5 can be reached by flipping three chosen check bits. The address is narrowed to 16 bits, which keeps the captured report values easy to read without changing the correction logic.

// File: rtl/mem_ecc_checker.sv
module mem_ecc_checker #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic              sbe_irq_en,
  input  logic              irq_clr,
  input  logic              rpt_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bus_err,
  output logic              irq,
  output logic              rpt_valid,
  output logic              rpt_overflow,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic [DATA_W-1:0] rpt_data,
  output logic [CHK_W-1:0]  rpt_chk,
  output logic              rpt_double
);
  localparam int HP     = CHK_W - 1;
  localparam int MAXPOS = DATA_W + HP;

  function automatic int data_pos(input int j);
    int cnt;
    cnt = 0;
    data_pos = 0;
    for (int p = 1; p <= MAXPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) data_pos = p;
        cnt++;
      end
    end
  endfunction

  logic [HP-1:0]     contrib [DATA_W];
  logic [HP-1:0]     calc, syn;
  logic [DATA_W-1:0] fixed;
  logic              par_odd, is_single, is_err, is_double, take;

  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    localparam int PI = data_pos(j);
    localparam logic [HP-1:0] PV = PI[HP-1:0];
    assign contrib[j] = rd_data[j] ? PV : '0;
    assign fixed[j]   = rd_data[j] ^ (is_single && syn == PV);
  end

  always_comb begin
    calc = '0;
    for (int j = 0; j < DATA_W; j++) calc ^= contrib[j];
  end

  assign syn       = calc ^ rd_chk[HP-1:0];
  assign par_odd   = ^{rd_data, rd_chk};
  assign is_single = par_odd && (int'(syn) <= MAXPOS);
  assign is_err    = par_odd || (syn != '0);
  assign is_double = is_err && !is_single;
  assign take      = rd_valid && is_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_bus_err <= 1'b0;
      irq         <= 1'b0;
    end else begin
      out_valid   <= rd_valid;
      out_bus_err <= rd_valid && is_double;
      if (rd_valid) out_data <= fixed;
      if (rd_valid && (is_double || (is_single && sbe_irq_en))) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid    <= 1'b0;
      rpt_overflow <= 1'b0;
      rpt_addr     <= '0;
      rpt_data     <= '0;
      rpt_chk      <= '0;
      rpt_double   <= 1'b0;
    end else if (take && (!rpt_valid || rpt_clr)) begin
      rpt_valid    <= 1'b1;
      rpt_overflow <= 1'b0;
      rpt_addr     <= rd_addr;
      rpt_data     <= rd_data;
      rpt_chk      <= rd_chk;
      rpt_double   <= is_double;
    end else if (rpt_clr) begin
      rpt_valid    <= 1'b0;
      rpt_overflow <= 1'b0;
    end else if (take) begin
      rpt_overflow <= 1'b1;
    end
  end

  assert_bus_err_in_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_bus_err |-> out_valid);
  assert_one_cycle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);
  assert_dbe_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_bus_err |-> irq);
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  assert_overflow_needs_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_overflow |-> rpt_valid);
  assert_record_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_clr |=> $stable(rpt_addr) && $stable(rpt_data) && $stable(rpt_chk));
endmodule

// File: tb/test_mem_ecc_checker.sv
`timescale 1ns/1ps
module test_mem_ecc_checker;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic rd_valid = 0, sbe_irq_en = 0, irq_clr = 0, rpt_clr = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data = '0;
  logic [CW-1:0] rd_chk = '0;
  logic out_valid, out_bus_err, irq, rpt_valid, rpt_overflow, rpt_double;
  logic [DW-1:0] out_data, rpt_data;
  logic [AW-1:0] rpt_addr;
  logic [CW-1:0] rpt_chk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R11";

  // model state
  logic m_ov, m_be, m_irq, m_rv, m_ovf, m_dbl;
  logic [DW-1:0] m_data, m_rdata;
  logic [AW-1:0] m_addr;
  logic [CW-1:0] m_rchk;

  always #2 clk = ~clk;

  mem_ecc_checker #(.DATA_W(DW), .CHK_W(CW), .ADDR_W(AW)) i_mem_ecc_checker (
    .clk, .rst_n, .rd_valid, .rd_addr, .rd_data, .rd_chk, .sbe_irq_en, .irq_clr, .rpt_clr,
    .out_valid, .out_data, .out_bus_err, .irq, .rpt_valid, .rpt_overflow,
    .rpt_addr, .rpt_data, .rpt_chk, .rpt_double);

  function automatic int bpos(int j);
    int seen = -1;
    for (int p = 1; p < 128; p++) begin
      if ($countones(p) != 1) seen++;
      if (seen == j) return p;
    end
    return 0;
  endfunction

  function automatic logic [CW-1:0] enc(logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int j = 0; j < DW; j++) begin
      int p = bpos(j);
      for (int i = 0; i < 7; i++) if (d[j] && ((p >> i) & 1)) c[i] = ~c[i];
    end
    c[7] = ^d ^ ^c[6:0];
    return c;
  endfunction

  task automatic model_edge();
    logic [CW-1:0] e;
    int s;
    bit odd, sgl, err, dbl;
    logic [DW-1:0] fix;
    if (!rst_n) begin
      m_ov = 0; m_be = 0; m_irq = 0; m_rv = 0; m_ovf = 0; m_dbl = 0;
      m_data = '0; m_rdata = '0; m_addr = '0; m_rchk = '0;
      return;
    end
    e = enc(rd_data);
    s = int'(e[6:0] ^ rd_chk[6:0]);
    odd = ^{rd_data, rd_chk};
    sgl = odd && s <= 71;
    err = odd || s != 0;
    dbl = err && !sgl;
    fix = rd_data;
    if (sgl) for (int j = 0; j < DW; j++) if (bpos(j) == s) fix[j] = ~fix[j];
    m_ov = rd_valid;
    m_be = rd_valid && dbl;
    if (rd_valid) m_data = fix;
    if (rd_valid && (dbl || (sgl && sbe_irq_en))) m_irq = 1;
    else if (irq_clr) m_irq = 0;
    if (rd_valid && err && (!m_rv || rpt_clr)) begin
      m_rv = 1; m_ovf = 0; m_addr = rd_addr; m_rdata = rd_data; m_rchk = rd_chk; m_dbl = dbl;
    end else if (rpt_clr) begin
      m_rv = 0; m_ovf = 0;
    end else if (rd_valid && err) m_ovf = 1;
  endtask

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("out_valid", 128'(out_valid), 128'(m_ov));
    chk("out_bus_err", 128'(out_bus_err), 128'(m_be));
    if (m_ov) chk("out_data", 128'(out_data), 128'(m_data));
    chk("irq", 128'(irq), 128'(m_irq));
    chk("report", {rpt_valid, rpt_overflow, rpt_double, rpt_addr, rpt_chk},
                  {m_rv, m_ovf, m_dbl, m_addr, m_rchk});
    if (m_rv) chk("rpt_data", 128'(rpt_data), 128'(m_rdata));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    rd_valid = 0; irq_clr = 0; rpt_clr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] d, logic [CW-1:0] c);
    rd_valid = 1; rd_addr = a; rd_data = d; rd_chk = c;
    tick();
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    @(negedge clk);
    tick(); tick();
    tag = "R11";
    chk("reset outputs", {out_valid, out_bus_err, irq, rpt_valid, rpt_overflow}, '0);
    rst_n = 1;
    tick();

    tag = "R1";
    rd(16'h0010, '0, enc('0));
    rd(16'h0011, '1, enc('1));
    d = 64'h0123_4567_89AB_CDEF; rd(16'h0012, d, enc(d));
    chk("no report on clean", 128'(rpt_valid), 128'(0));

    tag = "R2";
    d = rnd64(); rd(16'h0100, d ^ 64'h1, enc(d));
    chk("bit0 corrected", 128'(out_data), 128'(d));
    d = rnd64(); rd(16'h0101, d ^ (64'h1 << 63), enc(d));
    chk("bit63 corrected", 128'(out_data), 128'(d));
    tag = "R6";
    chk("no irq when disabled", 128'(irq), 128'(0));
    tag = "R8";
    chk("first record kept", {rpt_valid, rpt_addr, rpt_double}, {1'b1, 16'h0100, 1'b0});
    tag = "R9";
    chk("overflow set", 128'(rpt_overflow), 128'(1));
    rpt_clr = 1; tick();
    chk("clear record", {rpt_valid, rpt_overflow}, 2'b00);

    tag = "R3";
    for (int i = 0; i < CW; i++) begin
      d = rnd64(); rpt_clr = 1;
      rd(16'h0200 + AW'(i), d, enc(d) ^ CW'(1 << i));
      chk("check-bit flip", {out_bus_err, out_data, rpt_double}, {1'b0, d, 1'b0});
    end

    tag = "R6";
    sbe_irq_en = 1;
    d = rnd64(); rd(16'h0300, d ^ 64'h100, enc(d));
    chk("irq on single when enabled", 128'(irq), 128'(1));
    sbe_irq_en = 0;
    tag = "R7";
    irq_clr = 1; tick();
    chk("irq cleared", 128'(irq), 128'(0));

    tag = "R4";
    rpt_clr = 1;
    d = rnd64(); rd(16'h0400, d ^ 64'h3, enc(d));
    chk("double raw data", {out_bus_err, out_data, irq}, {1'b1, d ^ 64'h3, 1'b1});
    chk("double recorded", {rpt_double, rpt_addr}, {1'b1, 16'h0400});
    tag = "R7";
    irq_clr = 1; d = rnd64(); rd(16'h0401, d, enc(d) ^ 8'h0C);
    chk("set wins over clear", 128'(irq), 128'(1));
    irq_clr = 1; tick();

    tag = "R5";
    rpt_clr = 1;
    d = rnd64(); rd(16'h0500, d, enc(d) ^ 8'hC8);
    chk("out-of-range syndrome uncorrectable", {out_bus_err, out_data, rpt_double}, {1'b1, d, 1'b1});

    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom_range(0, 9));
      d = rnd64();
      sbe_irq_en = $urandom_range(0, 1) == 1;
      irq_clr = $urandom_range(0, 7) == 0;
      rpt_clr = $urandom_range(0, 7) == 0;
      if (r < 2) tick();
      else if (r < 5) rd(AW'($urandom()), d, enc(d));
      else if (r < 8) rd(AW'($urandom()), d ^ (64'h1 << $urandom_range(0, 63)), enc(d));
      else rd(AW'($urandom()), d ^ (64'h1 << $urandom_range(0, 31)) ^ (64'h1 << $urandom_range(32, 63)), enc(d));
    end
    finish_run();
  end
endmodule